// File: doc/BRIEF.md
# Daisy-Chain Serial Configuration Receiver

This block takes in a serial configuration stream for one programmable device that sits in a chain of such devices. An external configuration clock drives the whole block. The serial input is sampled on each rising edge of that clock. Bits the next device needs are retimed onto a serial output that changes on the falling edge, so the downstream device can sample them on its own following rising edge.

A stream opens with idle 1 bits. These are followed by an 8-bit start marker (0x5A, most significant bit first) and a 24-bit length count. The block repeats all of these downstream. It then keeps a fixed, parameterised number of bits for itself and shows them as a parallel set of frame words. When its own frame is complete it raises a done flag. From then on it passes every further bit downstream until it is reprogrammed.

The receiver only listens when the three mode inputs read 111 and the shared init-ready line is high. An active-low program input returns it to the hunting state. Board-level pull-ups make 111 the mode seen when the pins are left open.

Top module: `cfg_chain_rx`

## Requirements
- R1: `din` is sampled on the rising edge of `cclk`. A forwarded bit appears on `dout` at the next falling edge, half a period later, and holds until the falling edge after that.
- R2: While hunting for the start marker, every sampled bit is repeated on `dout`. This covers the idle 1s and the marker 0x5A (MSB first). The 24 length-count bits that follow the marker are also repeated.
- R3: The FRAME_BITS bits after the length count are kept locally, and `dout` stays 1 while they arrive.
- R4: Kept bits are packed into N_WORDS words of WORD_W bits. Word i sits at `frame_q[i*WORD_W +: WORD_W]`. Words fill in arrival order, and within a word the first bit received ends up as its MSB.
- R5: `done` rises after the rising edge that samples the last kept bit and then stays high. After that edge, every further bit is repeated on `dout` with the R1 timing.
- R6: When `mode` is not 3'b111, `din` is ignored: no state advances, no frame word changes, and `dout` is 1.
- R7: While `init_ok` is low, `din` is ignored and `dout` is 1. Hunting starts only once `init_ok` is high.
- R8: While `prog_n` is low at a rising edge, the block returns to hunting. This clears its counters, its frame words and `done`, and `dout` is 1 from the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Configuration clock, supplied externally |
| prog_n | input | 1 | Program request, active low, sampled on the rising edge |
| mode | input | 3 | Mode pins; 3'b111 selects serial slave reception |
| init_ok | input | 1 | Shared chain-ready line; high allows reception |
| din | input | 1 | Serial configuration data in |
| dout | output | 1 | Serial data out to the next device, changes on the falling edge |
| done | output | 1 | Own frame fully received |
| frame_q | output | WORD_W*N_WORDS | Captured frame words, word i at bits i*WORD_W upward |

## Verification
The assertions take three things for granted about the inputs. First, `prog_n` is held low from time zero until after the first rising edge, so the state is defined before any property is evaluated. Second, `din`, `mode` and `init_ok` are stable around each rising edge. Third, `prog_n` is also stable at the falling edge where the output stage samples it. The bench changes every input one nanosecond after a falling edge, so each input has settled well before both the next rising edge and the next falling edge. Input changes such as mode switches and init release are applied only at that point, never near an active edge.

// File: rtl/cfg_chain_pkg.sv
`timescale 1ns/1ps
package cfg_chain_pkg;

    localparam int          MARK_W     = 8;
    localparam logic [7:0]  MARKER     = 8'h5A;
    localparam int          LEN_BITS   = 24;
    localparam logic [2:0]  SLAVE_MODE = 3'b111;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_LEN,
        ST_OWN,
        ST_FWD
    } rx_state_e;

    typedef struct packed {
        logic capture;
        logic pass;
    } rx_ctl_t;

    function automatic logic marker_hit(input logic [MARK_W-2:0] win, input logic b);
        return ({win, b} == MARKER);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cfg_mode_gate.sv
`timescale 1ns/1ps
module cfg_mode_gate
    import cfg_chain_pkg::*;
(
    input  logic [2:0] mode,
    input  logic       init_ok,
    output logic       mode_ok,
    output logic       run_en
);

    always_comb begin
        mode_ok = (mode == SLAVE_MODE);
        run_en  = mode_ok && init_ok;
    end

endmodule

// File: rtl/cfg_seq.sv
`timescale 1ns/1ps
module cfg_seq
    import cfg_chain_pkg::*;
#(
    parameter int WORD_W  = 8,
    parameter int N_WORDS = 4,
    localparam int FRAME_BITS = WORD_W * N_WORDS,
    localparam int CNT_W   = $clog2(max2(LEN_BITS, FRAME_BITS)),
    localparam int IDX_W   = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
)(
    input  logic             clk,
    input  logic             clear,
    input  logic             run_en,
    input  logic             din,
    output rx_ctl_t          ctl,
    output logic [IDX_W-1:0] word_sel,
    output logic             fwd_q,
    output logic             done
);

    rx_state_e           state;
    logic [CNT_W-1:0]    cnt;
    logic [MARK_W-2:0]   win;

    always_ff @(posedge clk) begin
        if (clear) begin
            state <= ST_HUNT;
            cnt   <= '0;
            win   <= '1;
            fwd_q <= 1'b1;
            done  <= 1'b0;
        end else if (!run_en) begin
            fwd_q <= 1'b1;
        end else begin
            unique case (state)
                ST_HUNT: begin
                    fwd_q <= din;
                    win   <= {win[MARK_W-3:0], din};
                    if (marker_hit(win, din)) begin
                        state <= ST_LEN;
                        cnt   <= '0;
                    end
                end
                ST_LEN: begin
                    fwd_q <= din;
                    if (cnt == CNT_W'(LEN_BITS - 1)) begin
                        state <= ST_OWN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_OWN: begin
                    fwd_q <= 1'b1;
                    if (cnt == CNT_W'(FRAME_BITS - 1)) begin
                        state <= ST_FWD;
                        done  <= 1'b1;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_FWD: begin
                    fwd_q <= din;
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

    always_comb begin
        ctl.capture = run_en && (state == ST_OWN);
        ctl.pass    = run_en && (state != ST_OWN);
        word_sel    = IDX_W'(cnt / CNT_W'(WORD_W));
    end

    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (clear)
        done |=> done);

    // R5
    done_fwd_chk: assert property (@(posedge clk) disable iff (clear)
        done |-> (state == ST_FWD));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (clear)
        !run_en |=> ($stable(state) && $stable(cnt)));

    // R3
    own_quiet_chk: assert property (@(posedge clk) disable iff (clear)
        ctl.capture |=> fwd_q);

    // R8
    prog_clear_chk: assert property (@(posedge clk)
        clear |=> (!done && state == ST_HUNT && cnt == '0));

endmodule

// File: rtl/cfg_frame_store.sv
`timescale 1ns/1ps
module cfg_frame_store
#(
    parameter int WORD_W  = 8,
    parameter int N_WORDS = 4,
    localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
)(
    input  logic                      clk,
    input  logic                      clear,
    input  logic                      capture,
    input  logic [IDX_W-1:0]          word_sel,
    input  logic                      din,
    output logic [WORD_W*N_WORDS-1:0] frame_q
);

    for (genvar i = 0; i < N_WORDS; i++) begin : g_word
        logic [WORD_W-1:0] word_r;

        always_ff @(posedge clk) begin
            if (clear)
                word_r <= '0;
            else if (capture && (word_sel == IDX_W'(i)))
                word_r <= {word_r[WORD_W-2:0], din};
        end

        assign frame_q[i*WORD_W +: WORD_W] = word_r;
    end

    // R6
    frame_idle_chk: assert property (@(posedge clk) disable iff (clear)
        !capture |=> $stable(frame_q));

endmodule

// File: rtl/cfg_dout_retime.sv
`timescale 1ns/1ps
module cfg_dout_retime (
    input  logic clk,
    input  logic clear,
    input  logic fwd_q,
    output logic dout
);

    always_ff @(negedge clk) begin
        if (clear)
            dout <= 1'b1;
        else
            dout <= fwd_q;
    end

endmodule

// File: rtl/cfg_chain_rx.sv
`timescale 1ns/1ps
module cfg_chain_rx
    import cfg_chain_pkg::*;
#(
    parameter int WORD_W  = 8,
    parameter int N_WORDS = 4,
    localparam int FRAME_BITS = WORD_W * N_WORDS,
    localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
)(
    input  logic                  cclk,
    input  logic                  prog_n,
    input  logic [2:0]            mode,
    input  logic                  init_ok,
    input  logic                  din,
    output logic                  dout,
    output logic                  done,
    output logic [FRAME_BITS-1:0] frame_q
);

    logic             clear;
    logic             mode_ok;
    logic             run_en;
    rx_ctl_t          ctl;
    logic [IDX_W-1:0] word_sel;
    logic             fwd_q;

    assign clear = ~prog_n;

    cfg_mode_gate u_gate (
        .mode    (mode),
        .init_ok (init_ok),
        .mode_ok (mode_ok),
        .run_en  (run_en)
    );

    cfg_seq #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_seq (
        .clk      (cclk),
        .clear    (clear),
        .run_en   (run_en),
        .din      (din),
        .ctl      (ctl),
        .word_sel (word_sel),
        .fwd_q    (fwd_q),
        .done     (done)
    );

    cfg_frame_store #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_store (
        .clk      (cclk),
        .clear    (clear),
        .capture  (ctl.capture),
        .word_sel (word_sel),
        .din      (din),
        .frame_q  (frame_q)
    );

    cfg_dout_retime u_retime (
        .clk   (cclk),
        .clear (clear),
        .fwd_q (fwd_q),
        .dout  (dout)
    );

    // R6
    mode_quiet_chk: assert property (@(posedge cclk) disable iff (clear)
        !mode_ok |=> dout);

    // R6
    mode_no_capture_chk: assert property (@(posedge cclk) disable iff (clear)
        !mode_ok |-> !ctl.capture);

endmodule

// File: tb/tb_cfg_chain_rx.sv
`timescale 1ns/1ps
module tb_cfg_chain_rx;

    localparam int WORD_W  = 8;
    localparam int N_WORDS = 4;
    localparam int FB      = WORD_W * N_WORDS;
    localparam logic [7:0]  MARK = 8'h5A;
    localparam logic [23:0] LEN  = 24'h000028;

    // fields: mode[43:41], data[40:9], trail[8:1], expect_cfg[0]
    localparam logic [43:0] VEC [0:4] = '{
        {3'b111, 32'hA5C3_0F96, 8'h3C, 1'b1},
        {3'b111, 32'h0000_0001, 8'hFF, 1'b1},
        {3'b110, 32'h1234_5678, 8'h0F, 1'b0},
        {3'b011, 32'hDEAD_BEEF, 8'h55, 1'b0},
        {3'b111, 32'hFFFF_FFFF, 8'h00, 1'b1}
    };

    logic          cclk = 1'b0;
    logic          prog_n = 1'b0;
    logic [2:0]    mode = 3'b111;
    logic          init_ok = 1'b1;
    logic          din = 1'b1;
    logic          dout;
    logic          done;
    logic [FB-1:0] frame_q;

    int checks = 0;
    int errors = 0;

    always #2.5 cclk = ~cclk;

    cfg_chain_rx #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) dut (
        .cclk    (cclk),
        .prog_n  (prog_n),
        .mode    (mode),
        .init_ok (init_ok),
        .din     (din),
        .dout    (dout),
        .done    (done),
        .frame_q (frame_q)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic exp_d, input string req);
        din = b;
        @(posedge cclk);
        @(negedge cclk);
        #1;
        check(dout === exp_d, req, 64'(dout), 64'(exp_d));
    endtask

    function automatic logic [FB-1:0] pack_frame(input logic [FB-1:0] data);
        logic [FB-1:0] r;
        for (int w = 0; w < N_WORDS; w++)
            r[w*WORD_W +: WORD_W] = data[FB-1-w*WORD_W -: WORD_W];
        return r;
    endfunction

    // R8: program pulse clears everything
    task automatic do_reset();
        prog_n = 1'b0;
        din    = 1'b1;
        repeat (2) @(posedge cclk);
        @(negedge cclk);
        #1;
        check(dout === 1'b1, "R8 dout", 64'(dout), 64'd1);
        check(done === 1'b0, "R8 done", 64'(done), 64'd0);
        check(frame_q === '0, "R8 frame", 64'(frame_q), 64'd0);
        prog_n = 1'b1;
    endtask

    task automatic send_head(input logic cfg, input string tag);
        for (int i = 0; i < 6; i++) send_bit(1'b1, 1'b1, "R2 idle");
        for (int i = 7; i >= 0; i--)
            send_bit(MARK[i], cfg ? MARK[i] : 1'b1, cfg ? "R2 marker" : tag);
        for (int i = 23; i >= 0; i--)
            send_bit(LEN[i], cfg ? LEN[i] : 1'b1, cfg ? "R2 length" : tag);
    endtask

    task automatic run_stream(input logic cfg, input logic [FB-1:0] data,
                              input logic [7:0] trail, input string tag);
        logic [FB-1:0] exp_f;
        send_head(cfg, tag);
        for (int i = FB - 1; i >= 0; i--) begin
            send_bit(data[i], 1'b1, cfg ? "R3 own bit" : tag);
            check(done === (cfg && i == 0), cfg ? "R5 done timing" : tag,
                  64'(done), 64'(cfg && i == 0));
        end
        for (int i = 7; i >= 0; i--)
            send_bit(trail[i], cfg ? trail[i] : 1'b1, cfg ? "R5 overflow" : tag);
        exp_f = cfg ? pack_frame(data) : '0;
        check(frame_q === exp_f, cfg ? "R4 frame" : tag, 64'(frame_q), 64'(exp_f));
        check(done === cfg, cfg ? "R5 done" : tag, 64'(done), 64'(cfg));
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge cclk);
        #1;

        // table-driven streams: R2 R3 R4 R5 R6
        for (int e = 0; e < 5; e++) begin
            mode    = VEC[e][43:41];
            init_ok = 1'b1;
            do_reset();
            run_stream(VEC[e][0], VEC[e][40:9], VEC[e][8:1], "R6 ignored");
        end

        // R7: init low holds off reception, then release
        mode = 3'b111;
        do_reset();
        init_ok = 1'b0;
        run_stream(1'b0, 32'hCAFE_F00D, 8'hA5, "R7 held");
        init_ok = 1'b1;
        run_stream(1'b1, 32'hCAFE_F00D, 8'hA5, "R7 released");

        // R1: half-period retiming while forwarding
        send_bit(1'b1, 1'b1, "R1 setup");
        din = 1'b0;
        @(posedge cclk);
        #0.5;
        check(dout === 1'b1, "R1 before fall", 64'(dout), 64'd1);
        @(negedge cclk);
        #1;
        check(dout === 1'b0, "R1 after fall", 64'(dout), 64'd0);

        // R6: mode change after done stops forwarding, restore resumes
        mode = 3'b101;
        send_bit(1'b0, 1'b1, "R6 mode off");
        check(done === 1'b1, "R6 state kept", 64'(done), 64'd1);
        mode = 3'b111;
        send_bit(1'b0, 1'b0, "R6 mode back");

        // R8: program mid-frame, then a clean full stream
        do_reset();
        send_head(1'b1, "R2");
        for (int i = 0; i < 16; i++) send_bit(i[0], 1'b1, "R3 partial");
        do_reset();
        run_stream(1'b1, 32'h0F1E_2D3C, 8'hC3, "R8 restart");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule